// File: doc/BRIEF.md
# Mask and Status Interrupt Controller

This block collects thirty-two interrupt lines next to a CPU core and presents them as two special registers: an enable mask and a pending status. Software writes the mask to choose which lines may interrupt, reads the status to see which are pending, and writes the status to acknowledge. A single request line goes to the CPU while any enabled line is pending. A lowest-index encoder names the line that should be serviced first, so a handler loop can take pending lines in ascending order.

The way inputs reach the status register is fixed at build time by a parameter. In level mode the status register copies the input lines each cycle and ignores writes. In edge mode a rising edge on a line sets its bit, and writing a 1 to that bit clears it. In the legacy mode a high input level sets its bit and the bit stays set after the input drops. Writing a 0 clears the bit and writing a 1 leaves it alone. In both latching modes a new set event beats a clear in the same cycle.

Top module: `pic_core`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the mask and status registers are all zero, cpu_irq is 0 and pend_valid is 0.
- R2: A cycle with mask_wr_en high loads wr_data into the mask; with rd_sel = 0 rd_data returns the mask. Bit i = 1 enables line i.
- R3: In level mode (MODE = TRIG_LEVEL) the status bit i after a clock edge equals irq_in[i] sampled at that edge, and status writes have no effect.
- R4: In edge mode (MODE = TRIG_EDGE) a 0-to-1 change of irq_in[i] between two edges sets status bit i, which then stays set after the input falls. A status write clears every bit where wr_data is 1 and leaves bits where wr_data is 0.
- R5: In legacy mode (MODE = TRIG_LEGACY) irq_in[i] high at an edge sets status bit i, which stays set after the input falls. A status write clears every bit where wr_data is 0 and leaves bits where wr_data is 1.
- R6: In the two latching modes, when a set event and a clear write hit the same bit in the same cycle, the bit ends set.
- R7: cpu_irq is 1 exactly when some bit is set in both status and mask.
- R8: pend_valid equals cpu_irq; when valid, pend_idx is the lowest index i whose status and mask bits are both 1; when not valid, pend_idx is 0.
- R9: With rd_sel = 1, rd_data returns the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | Interrupt lines from peripherals |
| mask_wr_en | input | 1 | Write strobe for the enable mask |
| status_wr_en | input | 1 | Write strobe for the status (acknowledge) |
| wr_data | input | NUM_LINES | Data for either register write |
| rd_sel | input | 1 | Read select: 0 mask, 1 status |
| rd_data | output | NUM_LINES | Selected register contents |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| pend_valid | output | 1 | An enabled line is pending |
| pend_idx | output | IDX_W | Lowest pending enabled line index |

## Verification
A wrong status bit shows on rd_data one cycle after the edge that corrupts it. If the line is enabled, cpu_irq and pend_idx show it in the same cycle, because both are decoded from registers without further delay. A lost or spurious edge in the edge-detect register shows up as a status bit that fails to set, or one that sets on a steady high input, on the very next edge. A mask fault shows in the read-back and in a request that appears or vanishes against the expected pending set. Three instances run the same stimulus, one per mode, so a set or clear polarity error in any mode is caught on its first acknowledge write.

// File: rtl/pic_pkg.sv
// Shared types for the mask/status interrupt controller.
package pic_pkg;
    // Trigger and acknowledge behaviour of the status register.
    typedef enum logic [1:0] {
        TRIG_LEVEL  = 2'd0,
        TRIG_EDGE   = 2'd1,
        TRIG_LEGACY = 2'd2
    } trig_mode_e;
endpackage

// File: rtl/pic_mask_reg.sv
// Enable mask register. Loads the write data when strobed.
// Assumes: the write strobe is qualified by the CPU special-register decode.
module pic_mask_reg #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_LINES-1:0] wr_data,
    output logic [NUM_LINES-1:0] mask_q
);
    // Hold the enable bits; all lines disabled out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= wr_data;
    end
endmodule

// File: rtl/pic_status_reg.sv
// Pending status register. MODE picks how inputs set bits and how a
// write acknowledges them. In latching modes a set beats a clear.
// Assumes: irq_in is synchronous to clk.
module pic_status_reg #(
    parameter int                  NUM_LINES = 32,
    parameter pic_pkg::trig_mode_e MODE      = pic_pkg::TRIG_EDGE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 wr_en,
    input  logic [NUM_LINES-1:0] wr_data,
    output logic [NUM_LINES-1:0] status_q
);
    logic [NUM_LINES-1:0] set_vec;
    logic [NUM_LINES-1:0] clr_vec;

    generate
        if (MODE == pic_pkg::TRIG_EDGE) begin : g_edge
            logic [NUM_LINES-1:0] prev_q;
            // Remember last cycle's inputs for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= '0;
                else        prev_q <= irq_in;
            end
            // Rising edges set; a 1 in the write data clears.
            always_comb begin
                set_vec = irq_in & ~prev_q;
                clr_vec = wr_en ? wr_data : '0;
            end
        end else if (MODE == pic_pkg::TRIG_LEGACY) begin : g_legacy
            // High level sets; a 0 in the write data clears.
            always_comb begin
                set_vec = irq_in;
                clr_vec = wr_en ? ~wr_data : '0;
            end
        end else begin : g_level
            // Level mode: status is a registered copy, writes unused.
            always_comb begin
                set_vec = irq_in;
                clr_vec = '1;
            end
        end
    endgenerate

    // Apply clear first, then set, so a same-cycle set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/pic_lowest_enc.sv
// Lowest-set-bit encoder over the pending-and-enabled vector.
// Assumes: NUM_LINES is at least 2.
module pic_lowest_enc #(
    parameter int NUM_LINES = 32,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] req,
    output logic                 valid,
    output logic [IDX_W-1:0]     idx
);
    // Scan from the top so the lowest set bit is the last assignment.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pic_core.sv
// Mask and status interrupt controller: mask register, mode-selected
// status register, CPU request and lowest pending index.
// Assumes: one register write per cycle at most on each strobe.
module pic_core #(
    parameter int                  NUM_LINES = 32,
    parameter pic_pkg::trig_mode_e MODE      = pic_pkg::TRIG_EDGE,
    localparam int                 IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 mask_wr_en,
    input  logic                 status_wr_en,
    input  logic [NUM_LINES-1:0] wr_data,
    input  logic                 rd_sel,
    output logic [NUM_LINES-1:0] rd_data,
    output logic                 cpu_irq,
    output logic                 pend_valid,
    output logic [IDX_W-1:0]     pend_idx
);
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] status_q;
    logic [NUM_LINES-1:0] active;

    pic_mask_reg #(.NUM_LINES(NUM_LINES)) mask_i (
        .clk(clk), .rst_n(rst_n), .wr_en(mask_wr_en),
        .wr_data(wr_data), .mask_q(mask_q)
    );

    pic_status_reg #(.NUM_LINES(NUM_LINES), .MODE(MODE)) status_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(status_wr_en),
        .wr_data(wr_data), .status_q(status_q)
    );

    // Pending lines that are also enabled.
    assign active = status_q & mask_q;

    pic_lowest_enc #(.NUM_LINES(NUM_LINES)) enc_i (
        .req(active), .valid(pend_valid), .idx(pend_idx)
    );

    // Request the CPU whenever any enabled line is pending.
    assign cpu_irq = |active;

    // Special-register read mux.
    assign rd_data = rd_sel ? status_q : mask_q;
endmodule

// File: rtl/pic_core_chk.sv
// Assertion checker for pic_core, attached by bind.
module pic_core_chk #(
    parameter int                  NUM_LINES = 32,
    parameter pic_pkg::trig_mode_e MODE      = pic_pkg::TRIG_EDGE,
    localparam int                 IDX_W     = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_in,
    input logic                 mask_wr_en,
    input logic [NUM_LINES-1:0] wr_data,
    input logic [NUM_LINES-1:0] mask_q,
    input logic [NUM_LINES-1:0] status_q,
    input logic                 cpu_irq,
    input logic                 pend_valid,
    input logic [IDX_W-1:0]     pend_idx
);
    localparam logic [NUM_LINES-1:0] ONE = NUM_LINES'(1);
    logic [NUM_LINES-1:0] act;
    assign act = status_q & mask_q;

    assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_en |=> mask_q == $past(wr_data));

    assert_req_matches_enc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == pend_valid);

    assert_idx_is_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> act[pend_idx]);

    assert_idx_is_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (act & ((ONE << pend_idx) - ONE)) == '0);

    generate
        if (MODE == pic_pkg::TRIG_LEVEL) begin : g_lvl
            assert_level_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> status_q == $past(irq_in));
        end else begin : g_latch
            assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (status_q & ~$past(status_q) & ~$past(irq_in)) == '0);
            if (MODE == pic_pkg::TRIG_LEGACY) begin : g_leg
                assert_level_latches_R5: assert property (@(posedge clk) disable iff (!rst_n)
                    1'b1 |=> ($past(irq_in) & ~status_q) == '0);
            end
        end
    endgenerate
endmodule

bind pic_core pic_core_chk #(.NUM_LINES(NUM_LINES), .MODE(MODE)) chk_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_wr_en(mask_wr_en),
    .wr_data(wr_data), .mask_q(mask_q), .status_q(status_q),
    .cpu_irq(cpu_irq), .pend_valid(pend_valid), .pend_idx(pend_idx)
);

// File: tb/pic_core_tb_top.sv
`timescale 1ns/1ps
// Bench: three controllers (edge, level, legacy) on shared stimulus,
// compared against a bench model every cycle.
module pic_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        mask_wr_en = 1'b0;
    logic        status_wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;

    logic [31:0] rd_d [3];
    logic        irq_o [3];
    logic        pv_o [3];
    logic [4:0]  pi_o [3];

    int checks = 0;
    int errors = 0;

    logic [31:0] m_st [3];
    logic [31:0] m_mask;
    logic [31:0] m_prev;
    string       stag [3] = '{"R4", "R3", "R5"};

    always #4 clk = ~clk;

    pic_core #(.MODE(pic_pkg::TRIG_EDGE)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_wr_en(mask_wr_en),
        .status_wr_en(status_wr_en), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_d[0]), .cpu_irq(irq_o[0]), .pend_valid(pv_o[0]), .pend_idx(pi_o[0]));
    pic_core #(.MODE(pic_pkg::TRIG_LEVEL)) dut_lvl_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_wr_en(mask_wr_en),
        .status_wr_en(status_wr_en), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_d[1]), .cpu_irq(irq_o[1]), .pend_valid(pv_o[1]), .pend_idx(pi_o[1]));
    pic_core #(.MODE(pic_pkg::TRIG_LEGACY)) dut_leg_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_wr_en(mask_wr_en),
        .status_wr_en(status_wr_en), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_d[2]), .cpu_irq(irq_o[2]), .pend_valid(pv_o[2]), .pend_idx(pi_o[2]));

    // Compare one value and report a failure line.
    task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] lowest(input logic [31:0] v);
        logic [4:0] r = '0;
        for (int i = 31; i >= 0; i--) if (v[i]) r = 5'(i);
        return r;
    endfunction

    // Drive one cycle, advance the model at the edge, sample at the negedge.
    task automatic step(input logic [31:0] in, input logic mw, input logic sw,
                        input logic [31:0] wd, input logic rs);
        irq_in = in; mask_wr_en = mw; status_wr_en = sw; wr_data = wd; rd_sel = rs;
        @(posedge clk);
        m_st[0] = (m_st[0] & ~(sw ? wd : 32'h0)) | (in & ~m_prev);
        m_prev  = in;
        m_st[1] = in;
        m_st[2] = (m_st[2] & ~(sw ? ~wd : 32'h0)) | in;
        if (mw) m_mask = wd;
        @(negedge clk);
    endtask

    // Check every instance's outputs against the model.
    task automatic check_all(input string ctx);
        for (int k = 0; k < 3; k++) begin
            logic [31:0] a;
            a = m_st[k] & m_mask;
            if (rd_sel) ck({ctx, " R9 ", stag[k], " status"}, rd_d[k], m_st[k]);
            else        ck({ctx, " R2 mask"}, rd_d[k], m_mask);
            ck({ctx, " R7 cpu_irq"}, 32'(irq_o[k]), 32'(|a));
            ck({ctx, " R8 valid"}, 32'(pv_o[k]), 32'(|a));
            ck({ctx, " R8 idx"}, 32'(pi_o[k]), 32'(lowest(a)));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 3; k++) m_st[k] = '0;
        m_mask = '0; m_prev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        rd_sel = 1'b1; #1;
        for (int k = 0; k < 3; k++) begin
            ck("R1 status", rd_d[k], 32'h0);
            ck("R1 cpu_irq", 32'(irq_o[k]), 32'h0);
            ck("R1 pend_valid", 32'(pv_o[k]), 32'h0);
        end
        rd_sel = 1'b0; #1;
        for (int k = 0; k < 3; k++) ck("R1 mask", rd_d[k], 32'h0);
        @(negedge clk);

        // R2: enable everything.
        step(32'h0, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0);
        ck("R2 mask readback", rd_d[0], 32'hFFFF_FFFF);
        check_all("enable");

        // Pulse line 5: latching modes hold it, level mode follows.
        step(32'h20, 1'b0, 1'b0, 32'h0, 1'b1);
        step(32'h0, 1'b0, 1'b0, 32'h0, 1'b1);
        ck("R4 edge holds", rd_d[0], 32'h20);
        ck("R3 level follows", rd_d[1], 32'h0);
        ck("R5 legacy holds", rd_d[2], 32'h20);
        ck("R8 idx 5", 32'(pi_o[0]), 32'd5);
        check_all("pulse");

        // Write zeros: edge unchanged, legacy cleared.
        step(32'h0, 1'b0, 1'b1, 32'h0, 1'b1);
        ck("R4 write0 no effect", rd_d[0], 32'h20);
        ck("R5 write0 clears", rd_d[2], 32'h0);
        check_all("ack0");

        // Set line 8, then write ones: edge cleared, legacy unchanged.
        step(32'h100, 1'b0, 1'b0, 32'h0, 1'b1);
        step(32'h0, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1);
        ck("R4 write1 clears", rd_d[0], 32'h0);
        ck("R5 write1 no effect", rd_d[2], 32'h100);
        check_all("ack1");

        // R6: edge on line 3 and clear of line 3 in one cycle.
        step(32'h8, 1'b0, 1'b1, 32'h8, 1'b1);
        ck("R6 edge set wins", rd_d[0], 32'h8);
        ck("R3 level write ignored", rd_d[1], 32'h8);
        check_all("collide_edge");
        // R6: legacy high input while all bits are cleared.
        step(32'h8, 1'b0, 1'b1, 32'h0, 1'b1);
        ck("R6 legacy set wins", rd_d[2], 32'h8);
        check_all("collide_legacy");

        // R7/R8: pending lines all masked, then unmasked above line 7.
        step(32'hF00, 1'b1, 1'b0, 32'hF0, 1'b1);
        ck("R7 masked no irq", 32'(irq_o[0]), 32'h0);
        check_all("masked");
        step(32'hF00, 1'b1, 1'b0, 32'hFFFF_FF00, 1'b1);
        ck("R8 lowest 8", 32'(pi_o[2]), 32'd8);
        check_all("unmasked");

        // Random mix.
        for (int n = 0; n < 400; n++) begin
            logic [31:0] in, wd;
            logic mw, sw, rs;
            in = $urandom & $urandom;
            wd = $urandom;
            mw = ($urandom % 8) == 0;
            sw = ($urandom % 3) == 0;
            rs = $urandom % 2;
            step(in, mw, sw, wd, rs);
            check_all("random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule